// File: doc/BRIEF.md
# Prioritized Nested Interrupt Controller

This block collects a set of external interrupt lines and turns them into a single request to a processor core. For each source it keeps an enable bit, a pending bit, an active bit and a priority byte. It picks the most urgent source that is pending, enabled and not blocked by the core's base-priority threshold. It presents that source's vector number (source index plus 16) and its preempt level. Software can pend a source through a trigger register that takes the exception number minus 16. A control register sets the priority grouping and can raise a reset request, but only when the write carries a 16-bit key.

The core acknowledges the presented request. That moves the source from pending to active. The core signals end of service with the source index. A new request reaches the core while others are in service only if its preempt level is strictly more urgent than every active source's level. The register port is a plain single-cycle write strobe with a combinational read.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, the enable, pending and active sets are empty, all priorities and the grouping are 0, and both `irq_req` and `sys_reset_req` are low.
- R2: Writing ones to address 0 sets enables and writing ones to address 1 clears them; address 2 sets and address 3 clears pending bits. Reads at 0, 2 and 4 return the enable, pending and active sets. A cleared pending bit is discarded even if it was never serviced.
- R3: A pending bit is set by a rising edge of its line. A line held high does not set it again after it has been cleared.
- R4: Writing v to address 5 pends source v (vector v+16) exactly like a line edge; values of v at or above the source count have no effect.
- R5: A source is offered only when it is both pending and enabled, and `irq_vec` then equals its index plus 16.
- R6: The priority byte of source i is at address 32+i, and only its upper PRIO_BITS bits are stored (lower bits read 0). The offered source has the numerically lowest priority, with ties going to the lowest index.
- R7: A nonzero `base_mask` m blocks every source whose priority byte is m or greater; 0 blocks nothing.
- R8: Control bits 10:8 hold grouping k. The preempt part of a priority is its bits 7 down to k+1 (none for k=7), and `irq_level` shows the offered source's preempt part.
- R9: A control write takes effect only when bits 31:16 equal 0x05FA; otherwise grouping and reset request are unchanged.
- R10: A keyed control write with bit 2 set raises `sys_reset_req`, which stays high until reset.
- R11: `ack` while `irq_req` is high clears the offered source's pending bit and sets its active bit. `eoi` clears the active bit of source `eoi_id`.
- R12: While any source is active, a request is offered only if its preempt part is strictly lower than the lowest preempt part among active sources. Sub-priority never preempts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | NUM_SRC | External interrupt lines, edge-detected |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| base_mask | input | 8 | Base-priority threshold from the core, 0 = off |
| ack | input | 1 | Core takes the offered request |
| eoi | input | 1 | Core finished servicing a source |
| eoi_id | input | clog2(NUM_SRC) | Source index being finished |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | 8 | Vector number of the offered source |
| irq_level | output | 8 | Preempt part of the offered source's priority |
| sys_reset_req | output | 1 | Sticky system reset request |

## Verification
A corrupted pending, enable or priority bit shows up in the same cycle as a wrong `irq_req` or `irq_vec`. A read of the affected register shows it immediately too. A stale active bit is quieter: it only shows when a later request should have preempted and is withheld, so it appears at the first arrival whose preempt part falls between the true and the stale running level. A bad grouping value appears on `irq_level` at the next offered request. The bench compares every output against a cycle model on every cycle, so the first divergent cycle is reported.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NUM_SRC   = 8,
  parameter int PRIO_BITS = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SRC-1:0]         irq_lines,
  input  logic                       bus_wr,
  input  logic [5:0]                 bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  input  logic [7:0]                 base_mask,
  input  logic                       ack,
  input  logic                       eoi,
  input  logic [$clog2(NUM_SRC)-1:0] eoi_id,
  output logic                       irq_req,
  output logic [7:0]                 irq_vec,
  output logic [7:0]                 irq_level,
  output logic                       sys_reset_req
);
  localparam int IDW = $clog2(NUM_SRC);
  localparam logic [7:0] IMPL = 8'(9'h0FF << (8 - PRIO_BITS));
  localparam logic [15:0] KEY = 16'h05FA;
  localparam logic [5:0] A_ENS = 6'd0, A_ENC = 6'd1, A_PDS = 6'd2, A_PDC = 6'd3,
                         A_ACT = 6'd4, A_SWT = 6'd5, A_CTL = 6'd6;

  logic [NUM_SRC-1:0] en_q, pend_q, act_q, prev_q, elig;
  logic [7:0]         prio_q [NUM_SRC];
  logic [2:0]         grp_q;
  logic               rst_req_q;

  logic               found, has_act;
  logic [IDW-1:0]     sel;
  logic [7:0]         sel_p, run_p, grp_mask;
  logic [15:0]        gm_w;

  assign gm_w     = 16'h00FF << ({1'b0, grp_q} + 4'd1);
  assign grp_mask = gm_w[7:0];

  always_comb begin
    found = 1'b0; sel = '0; sel_p = 8'hFF;
    has_act = 1'b0; run_p = 8'hFF;
    for (int i = 0; i < NUM_SRC; i++) begin
      elig[i] = pend_q[i] && en_q[i] && (base_mask == 8'd0 || prio_q[i] < base_mask);
      if (elig[i] && (!found || prio_q[i] < sel_p)) begin
        found = 1'b1; sel = IDW'(i); sel_p = prio_q[i];
      end
      if (act_q[i] && (!has_act || (prio_q[i] & grp_mask) < run_p)) begin
        has_act = 1'b1; run_p = prio_q[i] & grp_mask;
      end
    end
  end

  assign irq_req       = found && (!has_act || (sel_p & grp_mask) < run_p);
  assign irq_vec       = 8'(sel) + 8'd16;
  assign irq_level     = sel_p & grp_mask;
  assign sys_reset_req = rst_req_q;

  wire wr_ctl_ok = bus_wr && bus_addr == A_CTL && bus_wdata[31:16] == KEY;
  wire take      = ack && irq_req;

  logic [NUM_SRC-1:0] sw_bit, ack_bit, eoi_bit, set_p, clr_p, set_e, clr_e;
  always_comb begin
    sw_bit  = '0;
    if (bus_wr && bus_addr == A_SWT && bus_wdata < 32'(NUM_SRC))
      sw_bit[bus_wdata[IDW-1:0]] = 1'b1;
    ack_bit = '0;
    if (take) ack_bit[sel] = 1'b1;
    eoi_bit = '0;
    if (eoi) eoi_bit[eoi_id] = 1'b1;
    set_e = (bus_wr && bus_addr == A_ENS) ? bus_wdata[NUM_SRC-1:0] : '0;
    clr_e = (bus_wr && bus_addr == A_ENC) ? bus_wdata[NUM_SRC-1:0] : '0;
    set_p = (bus_wr && bus_addr == A_PDS) ? bus_wdata[NUM_SRC-1:0] : '0;
    clr_p = (bus_wr && bus_addr == A_PDC) ? bus_wdata[NUM_SRC-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0; pend_q <= '0; act_q <= '0; prev_q <= '0;
      grp_q <= 3'd0; rst_req_q <= 1'b0;
      for (int i = 0; i < NUM_SRC; i++) prio_q[i] <= 8'd0;
    end else begin
      prev_q <= irq_lines;
      pend_q <= (pend_q & ~clr_p & ~ack_bit) | (irq_lines & ~prev_q) | sw_bit | set_p;
      en_q   <= (en_q | set_e) & ~clr_e;
      act_q  <= (act_q | ack_bit) & ~eoi_bit;
      for (int i = 0; i < NUM_SRC; i++)
        if (bus_wr && bus_addr == 6'(32 + i)) prio_q[i] <= bus_wdata[7:0] & IMPL;
      if (wr_ctl_ok) begin
        grp_q <= bus_wdata[10:8];
        if (bus_wdata[2]) rst_req_q <= 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_ENS: bus_rdata[NUM_SRC-1:0] = en_q;
      A_PDS: bus_rdata[NUM_SRC-1:0] = pend_q;
      A_ACT: bus_rdata[NUM_SRC-1:0] = act_q;
      A_CTL: bus_rdata[10:8] = grp_q;
      default: if (bus_addr[5] && int'(bus_addr[4:0]) < NUM_SRC)
                 bus_rdata[7:0] = prio_q[bus_addr[4:0]];
    endcase
  end

  // R5: only an enabled, pending source is ever offered
  p_offer_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (en_q[sel] && pend_q[sel]));
  // R7: offered source respects the threshold
  p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && base_mask != 8'd0) |-> prio_q[sel] < base_mask);
  // R9: a keyless control write leaves grouping alone
  p_key_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CTL && bus_wdata[31:16] != KEY) |=> $stable(grp_q));
  // R10: reset request is sticky
  p_rstreq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |=> sys_reset_req);
  // R11: a taken request becomes active
  p_ack_active_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !(eoi && eoi_id == sel)) |=> act_q[$past(sel)]);
  // R12: the same source is never offered while it is active
  p_no_self_preempt_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !act_q[sel]);
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  localparam int N = 8;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] irq_lines = '0;
  logic bus_wr = 0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [7:0] base_mask = '0;
  logic ack = 0, eoi = 0;
  logic [2:0] eoi_id = '0;
  logic irq_req, sys_reset_req;
  logic [7:0] irq_vec, irq_level;

  always #10 clk = ~clk;

  prio_irq_ctrl #(.NUM_SRC(N), .PRIO_BITS(3)) dut_i (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  logic [N-1:0] m_en, m_pend, m_act, m_prev;
  logic [7:0] m_prio [N];
  logic [2:0] m_grp;
  logic m_rst, e_req;
  int e_sel;
  logic [7:0] e_selp;

  function automatic logic [7:0] pre_of(logic [7:0] p);
    logic [15:0] t = 16'h00FF << (int'(m_grp) + 1);
    return p & t[7:0];
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic m_reset();
    m_en = '0; m_pend = '0; m_act = '0; m_prev = '0; m_grp = 0; m_rst = 0;
    for (int i = 0; i < N; i++) m_prio[i] = 0;
  endtask

  task automatic m_eval();
    bit fnd = 0, ha = 0;
    logic [7:0] rp = 8'hFF;
    e_sel = 0; e_selp = 8'hFF;
    for (int i = 0; i < N; i++) begin
      if (m_pend[i] && m_en[i] && (base_mask == 0 || m_prio[i] < base_mask) &&
          (!fnd || m_prio[i] < e_selp)) begin
        fnd = 1; e_sel = i; e_selp = m_prio[i];
      end
      if (m_act[i] && (!ha || pre_of(m_prio[i]) < rp)) begin
        ha = 1; rp = pre_of(m_prio[i]);
      end
    end
    e_req = fnd && (!ha || pre_of(e_selp) < rp);
  endtask

  function automatic logic [31:0] m_read(logic [5:0] a);
    if (a == 0) return 32'(m_en);
    if (a == 2) return 32'(m_pend);
    if (a == 4) return 32'(m_act);
    if (a == 6) return {21'd0, m_grp, 8'd0};
    if (a[5] && a[4:0] < N) return 32'(m_prio[a[4:0]]);
    return 0;
  endfunction

  task automatic m_update();
    logic [N-1:0] sw = '0, ab = '0, eb = '0;
    if (bus_wr && bus_addr == 5 && bus_wdata < N) sw[bus_wdata[2:0]] = 1;
    if (ack && e_req) ab[e_sel] = 1;
    if (eoi) eb[eoi_id] = 1;
    m_pend = (m_pend & ~ab) | (irq_lines & ~m_prev) | sw;
    if (bus_wr) begin
      case (bus_addr)
        0: m_en = m_en | bus_wdata[N-1:0];
        1: m_en = m_en & ~bus_wdata[N-1:0];
        2: m_pend = m_pend | bus_wdata[N-1:0];
        3: m_pend = m_pend & ~bus_wdata[N-1:0] | (irq_lines & ~m_prev) | sw;
        6: if (bus_wdata[31:16] == 16'h05FA) begin
             m_grp = bus_wdata[10:8];
             if (bus_wdata[2]) m_rst = 1;
           end
        default: if (bus_addr[5] && bus_addr[4:0] < N) m_prio[bus_addr[4:0]] = bus_wdata[7:0] & 8'hE0;
      endcase
    end
    m_act = (m_act | ab) & ~eb;
    m_prev = irq_lines;
  endtask

  // outputs checked after the negedge drive, state updated on posedge
  task automatic cycle();
    #1;
    m_eval();
    chk(irq_req, e_req, "R5/R6/R7/R12 irq_req");
    if (e_req) begin
      chk(irq_vec, e_sel + 16, "R5/R6 irq_vec");
      chk(irq_level, pre_of(e_selp), "R8 irq_level");
    end
    chk(sys_reset_req, m_rst, "R10 sys_reset_req");
    if (!bus_wr) chk(bus_rdata, m_read(bus_addr), "R2/R6 bus_rdata");
    @(posedge clk);
    m_update();
    @(negedge clk);
    bus_wr = 0; ack = 0; eoi = 0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; cycle();
  endtask

  function automatic logic [31:0] rd(input logic [5:0] a);
    return 0;
  endfunction

  task automatic peek(input logic [5:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a; #1; chk(bus_rdata, exp, tag);
  endtask

  task automatic do_reset();
    rst_n = 0; m_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset();
    // R1 reset state
    peek(0, 0, "R1 enables"); peek(2, 0, "R1 pending"); peek(4, 0, "R1 active");
    peek(6, 0, "R1 ctrl"); peek(6'd33, 0, "R1 prio");
    chk(irq_req, 0, "R1 irq_req"); chk(sys_reset_req, 0, "R1 reset req");
    // R6 implemented bits only
    wr(6'd33, 32'hFF); peek(6'd33, 32'hE0, "R6 prio truncation");
    wr(6'd33, 32'h40); wr(6'd35, 32'h40); wr(0, 32'h0A);
    peek(0, 32'h0A, "R2 enable set");
    wr(5, 3); chk(irq_vec, 19, "R4 sw trigger vector"); chk(irq_req, 1, "R5 offered");
    wr(5, 1); chk(irq_vec, 17, "R6 tie lowest index");
    wr(5, 8); peek(2, 32'h0A, "R4 out of range ignored");
    wr(6'd35, 32'h20); chk(irq_vec, 19, "R6 lower value wins");
    base_mask = 8'h20; #1; chk(irq_req, 0, "R7 mask blocks equal and above");
    base_mask = 8'h40; #1; chk(irq_vec, 19, "R7 mask admits below");
    base_mask = 0;
    wr(3, 32'h08); chk(irq_vec, 17, "R2 clear pending discards"); peek(2, 32'h02, "R2 pending read");
    wr(1, 32'h02); chk(irq_req, 0, "R5 disabled not offered"); peek(2, 32'h02, "R5 pend kept");
    wr(0, 32'h06);
    irq_lines[2] = 1; cycle(); chk(irq_vec, 18, "R3 edge pends");
    wr(3, 32'h04); cycle(); peek(2, 32'h02, "R3 held line no re-pend");
    irq_lines[2] = 0; cycle(); irq_lines[2] = 1; cycle();
    chk(irq_vec, 18, "R3 new edge pends");
    ack = 1; cycle(); peek(4, 32'h04, "R11 ack sets active"); peek(2, 32'h02, "R11 ack clears pending");
    chk(irq_req, 0, "R12 no preempt at equal or worse level");
    eoi = 1; eoi_id = 2; cycle(); peek(4, 0, "R11 eoi clears active");
    chk(irq_vec, 17, "R11 next offered after eoi");
    ack = 1; cycle(); wr(5, 3); chk(irq_vec, 19, "R12 preempt strictly lower");
    wr(6, 32'h1234_0700); peek(6, 0, "R9 bad key ignored");
    wr(6, 32'h05FA_0600); peek(6, 32'h600, "R9 keyed write");
    chk(irq_req, 0, "R12 sub-priority never preempts");
    wr(6, 32'h05FA_0400); chk(irq_level, 8'h20, "R8 preempt part");
    wr(6, 32'h0000_0004); chk(sys_reset_req, 0, "R9 keyless reset ignored");
    wr(6, 32'h05FA_0404); chk(sys_reset_req, 1, "R10 reset req raised");
    cycle(); chk(sys_reset_req, 1, "R10 reset req sticky");

    do_reset();
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom % 10;
      if ($urandom % 4 == 0) irq_lines = irq_lines ^ N'($urandom);
      base_mask = ($urandom % 3 == 0) ? 8'($urandom) & 8'hE0 : 8'd0;
      ack = ($urandom % 3 == 0);
      eoi = ($urandom % 5 == 0); eoi_id = 3'($urandom);
      bus_addr = 6'($urandom % 8);
      if (r < 4) begin
        bus_wr = 1;
        case ($urandom % 7)
          0: begin bus_addr = 0; bus_wdata = $urandom; end
          1: begin bus_addr = 1; bus_wdata = $urandom & 32'h3; end
          2: begin bus_addr = 2; bus_wdata = $urandom; end
          3: begin bus_addr = 3; bus_wdata = $urandom; end
          4: begin bus_addr = 5; bus_wdata = $urandom % 12; end
          5: begin bus_addr = 6; bus_wdata = {($urandom % 2) ? 16'h05FA : 16'($urandom), 16'($urandom) & 16'h0700}; end
          default: begin bus_addr = 6'(32 + $urandom % N); bus_wdata = $urandom; end
        endcase
      end else if (r < 6) bus_addr = 6'(32 + $urandom % N);
      cycle();
    end
    finish_run();
  end
endmodule